// File: doc/BRIEF.md
# Bit-Field Extract Unit with Flags

This unit pulls a contiguous run of bits out of a 32-bit source word and returns it right-aligned in a 32-bit result. The upper bits of the result are either zero-filled or copied from the top bit of the field, depending on a signed-mode input. The position and length of the field both come from one packed control operand. The low byte of that operand gives the starting bit and the next byte gives the number of bits.

Fields that are empty or that run past the word have fixed results. A zero length always gives zero. A field that starts beyond bit 31 gives a pure fill value. A field that runs off the top of the word is cut at bit 31.

When a condition-code update is requested, the unit also produces four flags and a write strobe. Zero and sign describe the result, and carry and overflow are forced clear. When no update is requested, the stored flags keep their values.

The parameter `REG_OUT` adds one output register. Its default is 1, which gives a one-cycle latency.

Top module: `bfx_unit`

## Requirements
- R1: The field start is taken from control bits [7:0] and the field length from control bits [15:8]. Control bits [31:16] have no effect on any output.
- R2: With signed mode clear, the result holds source bits [start+len-1:start] in its low bits, and every bit above the field is 0.
- R3: With signed mode set, every bit above the field equals the highest extracted bit.
- R4: A field length of 0 gives a result of 0 in either mode, even when the start is 32 or more.
- R5: If start plus length exceeds 32, the field ends at source bit 31. In signed mode the fill bit is then source bit 31. Lengths up to 255 are accepted.
- R6: With a nonzero length and a start of 32 or more, the result is 0x00000000. The one exception is signed mode with source bit 31 set, where the result is 0xFFFFFFFF.
- R7: When flag update is enabled, the flag-write strobe is 1, zero is 1 exactly when the result is 0, sign equals result bit 31, and carry and overflow are 0.
- R8: When flag update is disabled, the flag-write strobe is 0 and all four flags keep their previous values, while the result still updates.
- R9: With `REG_OUT`=1, the result, flags and strobe appear on the clock edge after the inputs are applied. A low `rst_n` at a clock edge clears them all to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Source word |
| ctl_i | input | 32 | Packed control operand: start in [7:0], length in [15:8] |
| signed_i | input | 1 | 1 = sign-extend the field, 0 = zero-fill |
| flag_en_i | input | 1 | Condition-code update enable |
| result_o | output | 32 | Extracted, right-aligned field |
| flag_z_o | output | 1 | Zero flag |
| flag_s_o | output | 1 | Sign flag |
| flag_c_o | output | 1 | Carry flag, cleared on update |
| flag_v_o | output | 1 | Overflow flag, cleared on update |
| flag_we_o | output | 1 | Flag-write strobe |

## Verification
The bench targets fields that run off the top of the word with both a negative and a positive top bit. A design that did not clip would wrap or fill from the wrong bit. It also uses starts of exactly 32 and of 255; a design that wrapped the start into five bits would extract real data there. Zero-length fields are paired with an out-of-range start to show that the zero result takes priority over the fill value. Further cases are a full 32-bit field, a one-bit signed field, junk in the unused control bits, and disabling the flag update; a design that ignored the enable would corrupt the held zero and sign flags.

// File: rtl/bfx_pkg.sv
// Shared types for the bit-field extract unit.
// Assumes nothing beyond a 4-state SystemVerilog compiler.
package bfx_pkg;
    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic v;
    } bfx_flags_t;
endpackage

// File: rtl/bfx_decode.sv
// Splits the packed control operand into start and length. It flags a
// zero length and an out-of-range start, and clips the length so the
// field ends no higher than bit W-1.
// Assumes W fits in FW bits, so the start byte can express W itself.
module bfx_decode #(
    parameter int W  = 32,
    parameter int FW = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0] ctl,
    output logic [IW-1:0] pos_idx,
    output logic [IW:0]   eff_len,
    output logic          len_zero,
    output logic          pos_oob
);
    logic [FW-1:0] pos;
    logic [FW-1:0] len;
    logic [FW:0]   room;
    logic [FW:0]   clipped;
    logic          ctl_unused_hi;

    // Slice the two descriptor bytes; the remaining bits are don't-care.
    assign pos           = ctl[FW-1:0];
    assign len           = ctl[2*FW-1:FW];
    assign ctl_unused_hi = ^ctl[W-1:2*FW];

    // Classify the descriptor and clip the length to the bits left above the start.
    always_comb begin
        len_zero = (len == '0);
        pos_oob  = ({1'b0, pos} >= (FW+1)'(W));
        room     = pos_oob ? '0 : ((FW+1)'(W) - {1'b0, pos});
        clipped  = ({1'b0, len} > room) ? room : {1'b0, len};
        eff_len  = (IW+1)'(clipped);
        pos_idx  = IW'(pos);
    end
endmodule

// File: rtl/bfx_extract.sv
// Shifts the source right by the start and keeps eff_len bits. Bits above
// the field are filled with zero or with the top extracted bit.
// Assumes eff_len is already clipped; the special cases take priority.
module bfx_extract #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [IW-1:0] pos_idx,
    input  logic [IW:0]   eff_len,
    input  logic          len_zero,
    input  logic          pos_oob,
    input  logic          sgn,
    output logic [W-1:0]  res
);
    logic [W-1:0]  shifted;
    logic [W-1:0]  in_field;
    logic [IW-1:0] top_idx;
    logic [IW:0]   top_wide;
    logic          fill_bit;

    // One comparator per bit marks the positions inside the field.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign in_field[i] = ((IW+1)'(i) < eff_len);
    end

    // Align the field and choose the fill bit.
    always_comb begin
        shifted  = src >> pos_idx;
        top_wide = eff_len - 1'b1;
        top_idx  = IW'(top_wide);
        fill_bit = sgn & shifted[top_idx];
    end

    // Merge the field with its fill; zero length wins over an out-of-range start.
    always_comb begin
        if (len_zero)
            res = '0;
        else if (pos_oob)
            res = {W{sgn & src[W-1]}};
        else
            res = (shifted & in_field) | (~in_field & {W{fill_bit}});
    end
endmodule

// File: rtl/bfx_flags.sv
// Derives the condition flags from a result word.
// Assumes the result is read as two's complement for the sign flag.
module bfx_flags
    import bfx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    output bfx_flags_t   flags
);
    // Zero and sign follow the result; carry and overflow are always cleared.
    always_comb begin
        flags.z = ~|res;
        flags.s = res[W-1];
        flags.c = 1'b0;
        flags.v = 1'b0;
    end
endmodule

// File: rtl/bfx_unit.sv
// Top of the bit-field extract unit: decode, extract, flags and an
// optional output register (REG_OUT). The flag state is always held in a
// register so that it can be kept while the update is disabled.
// Assumes a synchronous active-low reset.
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int W       = 32,
    parameter int FW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [31:0]  src_i,
    input  logic [31:0]  ctl_i,
    input  logic         signed_i,
    input  logic         flag_en_i,
    output logic [31:0]  result_o,
    output logic         flag_z_o,
    output logic         flag_s_o,
    output logic         flag_c_o,
    output logic         flag_v_o,
    output logic         flag_we_o
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] pos_idx;
    logic [IW:0]   eff_len;
    logic          len_zero;
    logic          pos_oob;
    logic [W-1:0]  res_c;
    bfx_flags_t    flags_c;
    bfx_flags_t    flags_q;
    bfx_flags_t    flags_out;

    bfx_decode #(.W(W), .FW(FW)) u_decode (
        .ctl      (ctl_i),
        .pos_idx  (pos_idx),
        .eff_len  (eff_len),
        .len_zero (len_zero),
        .pos_oob  (pos_oob)
    );

    bfx_extract #(.W(W)) u_extract (
        .src      (src_i),
        .pos_idx  (pos_idx),
        .eff_len  (eff_len),
        .len_zero (len_zero),
        .pos_oob  (pos_oob),
        .sgn      (signed_i),
        .res      (res_c)
    );

    bfx_flags #(.W(W)) u_flags (
        .res   (res_c),
        .flags (flags_c)
    );

    // Flag state register: loads only on an enabled update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flag_en_i)
            flags_q <= flags_c;
    end

    if (REG_OUT) begin : g_reg
        logic [W-1:0] result_q;
        logic         we_q;

        // Output register for the result and the strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_q <= '0;
                we_q     <= 1'b0;
            end else begin
                result_q <= res_c;
                we_q     <= flag_en_i;
            end
        end

        assign result_o  = result_q;
        assign flag_we_o = we_q;
        assign flags_out = flags_q;

        // R4: zero length gives a zero result.
        p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
            len_zero |=> (result_o == '0));

        // R6: an out-of-range start gives the fill value.
        p_oob_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!len_zero && pos_oob) |=> (result_o == {W{$past(signed_i && src_i[W-1])}}));

        // R2: in unsigned mode nothing is set above the clipped field.
        p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!signed_i && !len_zero && !pos_oob) |=> ((result_o >> $past(eff_len)) == '0));

        // R7: an update clears carry and overflow.
        p_cv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flag_we_o |-> (!flag_c_o && !flag_v_o));

        // R7: an update makes zero and sign describe the result.
        p_zs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flag_we_o |-> ((flag_z_o == (result_o == '0)) && (flag_s_o == result_o[W-1])));

        // R8: without an update the strobe is low and the flags are kept.
        p_hold_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_en_i |=> (!flag_we_o && $stable({flag_z_o, flag_s_o, flag_c_o, flag_v_o})));
    end else begin : g_comb
        assign result_o  = res_c;
        assign flag_we_o = flag_en_i;
        assign flags_out = flag_en_i ? flags_c : flags_q;
    end

    assign flag_z_o = flags_out.z;
    assign flag_s_o = flags_out.s;
    assign flag_c_o = flags_out.c;
    assign flag_v_o = flags_out.v;
endmodule

// File: tb/test_bfx_unit.sv
// Bench for bfx_unit (REG_OUT=1): a vector table followed by directed checks.
module test_bfx_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    // Vector layout: {req, src, ctl, signed, expected}; ctl = {len, start}.
    localparam logic [100:0] VECS [NV] = '{
        {4'd2, 32'h1234_5678, 32'h0000_0804, 1'b0, 32'h0000_0067}, // R2 basic
        {4'd3, 32'h1234_5678, 32'h0000_0804, 1'b1, 32'h0000_0067}, // R3 positive field
        {4'd2, 32'h0000_0F00, 32'h0000_0408, 1'b0, 32'h0000_000F}, // R2
        {4'd3, 32'h0000_0F00, 32'h0000_0408, 1'b1, 32'hFFFF_FFFF}, // R3 negative field
        {4'd1, 32'h1234_5678, 32'hABCD_0804, 1'b0, 32'h0000_0067}, // R1 junk in [31:16]
        {4'd4, 32'hFFFF_FFFF, 32'h0000_0010, 1'b1, 32'h0000_0000}, // R4
        {4'd4, 32'hFFFF_FFFF, 32'h0000_0028, 1'b1, 32'h0000_0000}, // R4 beats R6
        {4'd5, 32'h8000_0000, 32'h0000_081C, 1'b0, 32'h0000_0008}, // R5 clipped
        {4'd5, 32'h8000_0000, 32'h0000_081C, 1'b1, 32'hFFFF_FFF8}, // R5 fill from bit 31
        {4'd5, 32'h7000_0000, 32'h0000_C81C, 1'b1, 32'h0000_0007}, // R5 length 200
        {4'd6, 32'h8000_0000, 32'h0000_0420, 1'b1, 32'hFFFF_FFFF}, // R6 start 32
        {4'd6, 32'h8000_0000, 32'h0000_0420, 1'b0, 32'h0000_0000}, // R6 unsigned
        {4'd6, 32'h7FFF_FFFF, 32'h0000_01FF, 1'b1, 32'h0000_0000}, // R6 start 255
        {4'd2, 32'hDEAD_BEEF, 32'h0000_2000, 1'b0, 32'hDEAD_BEEF}, // R2 full width
        {4'd5, 32'hDEAD_BEEF, 32'h0000_2100, 1'b1, 32'hDEAD_BEEF}, // R5 length 33
        {4'd3, 32'h8000_0000, 32'h0000_011F, 1'b1, 32'hFFFF_FFFF}, // R3 one bit at 31
        {4'd2, 32'h8000_0000, 32'h0000_011F, 1'b0, 32'h0000_0001}, // R2 one bit at 31
        {4'd3, 32'h0000_0001, 32'h0000_0100, 1'b1, 32'hFFFF_FFFF}  // R3 one bit at 0
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_i;
    logic [31:0] ctl_i;
    logic        signed_i;
    logic        flag_en_i;
    logic [31:0] result_o;
    logic        flag_z_o, flag_s_o, flag_c_o, flag_v_o, flag_we_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfx_unit i_bfx_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .ctl_i     (ctl_i),
        .signed_i  (signed_i),
        .flag_en_i (flag_en_i),
        .result_o  (result_o),
        .flag_z_o  (flag_z_o),
        .flag_s_o  (flag_s_o),
        .flag_c_o  (flag_c_o),
        .flag_v_o  (flag_v_o),
        .flag_we_o (flag_we_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic z, input logic s,
                               input logic we);
        check(req, "flag_z", {31'd0, flag_z_o}, {31'd0, z});
        check(req, "flag_s", {31'd0, flag_s_o}, {31'd0, s});
        check(req, "flag_c", {31'd0, flag_c_o}, 32'd0);
        check(req, "flag_v", {31'd0, flag_v_o}, 32'd0);
        check(req, "flag_we", {31'd0, flag_we_o}, {31'd0, we});
    endtask

    task automatic drive(input logic [31:0] s, input logic [31:0] c,
                         input logic sg, input logic fe);
        src_i = s; ctl_i = c; signed_i = sg; flag_en_i = fe;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(32'hFFFF_FFFF, 32'h0000_2000, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        // R9: reset holds every output at zero despite active inputs.
        check("R9", "reset result", result_o, 32'd0);
        check_flags("R9", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [100:0] v;
            v = VECS[k];
            drive(v[96:65], v[64:33], v[32], 1'b1);
            @(negedge clk);
            check($sformatf("R%0d", v[100:97]), "result", result_o, v[31:0]);
            // R7: flags follow the result, carry and overflow are clear.
            check_flags("R7", (v[31:0] == 32'd0), v[31], 1'b1);
        end

        // R9: new inputs do not reach the result before the clock edge.
        drive(32'h0000_00FF, 32'h0000_0800, 1'b0, 1'b1);
        #1;
        check("R9", "before edge", result_o, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9", "after edge", result_o, 32'h0000_00FF);

        // R8: load Z=0 S=1, then disable the update and produce a zero result.
        drive(32'hFFFF_FFFF, 32'h0000_2000, 1'b1, 1'b1);
        @(negedge clk);
        check_flags("R7", 1'b0, 1'b1, 1'b1);
        drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0);
        @(negedge clk);
        check("R8", "result still updates", result_o, 32'd0);
        check_flags("R8", 1'b0, 1'b1, 1'b0);
        drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1);
        @(negedge clk);
        check_flags("R7", 1'b1, 1'b0, 1'b1);

        // R9: a reset mid-run clears the result and the flags.
        drive(32'hFFFF_FFFF, 32'h0000_2000, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "mid-run reset", result_o, 32'd0);
        check_flags("R9", 1'b0, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule